// File: doc/BRIEF.md
# Smart Card Block-Mode Character Transmitter

This block serialises one byte at a time onto a smart card data line in block transfer mode. An accepted byte becomes a ten-bit character: a low start bit, eight data bits and a parity bit, each one elementary time unit (etu) long. The etu length is a selectable whole number of clock cycles. Each clock cycle of the block is one basic-clock cycle. The line is modelled as an open-drain wire. `line_o` high means the wire is released and pulled to the idle level. `line_o` low means the block pulls it down.

Each byte can be sent in one of two conventions. In the direct convention the data goes out least significant bit first, at its true level. In the inverse convention the data goes out most significant bit first, with every data bit inverted. The parity bit does not follow the convention. It is even parity over the byte, unless odd parity is selected, so a user of the inverse convention inverts it by choosing odd parity.

Block mode has no error-signal exchange, so a character is sent exactly once. After the parity bit the line stays released for a guard period before the next byte can be taken. A transmit-end flag rises half an etu into the second guard etu, which is 11.5 etu after the start bit began. The flag stays set until the next byte is accepted. All frame settings are captured when the byte is accepted.

Top module: `sc_blk_tx`

## Requirements
- R1: After reset `tx_ready` is 1, `line_o` is 1 and `tx_end` is 0.
- R2: A byte is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` reads 0 from that edge until the guard period ends, and `tx_valid` pulses during that time are ignored.
- R3: `ratio_sel` sets the etu length N in clock cycles: 00 gives 32, 01 gives 64, 10 gives 372 and 11 gives 256. Bit k of the frame is driven from N·k to N·(k+1) cycles after the accepting edge.
- R4: The frame is bit 0, a start bit at level 0, then data positions 1 to 8, then the parity bit at position 9. `line_o` changes only on etu boundaries.
- R5: With `inv_conv`=0, position k (1..8) carries `tx_data[k-1]` without inversion.
- R6: With `inv_conv`=1, position k (1..8) carries the inverse of `tx_data[8-k]`.
- R7: The parity bit level is the XOR of the eight bits of `tx_data` XOR `odd_par`, whatever the convention.
- R8: After the parity bit, `line_o` stays 1 for GUARD_ETU etu (default 2, never less than 2). `tx_ready` returns to 1 exactly N·(10+GUARD_ETU) cycles after the accepting edge.
- R9: `tx_end` rises exactly 11·N + N/2 cycles after the accepting edge. It stays 1 while idle and clears on the next accepting edge.
- R10: A character is never repeated. With no new byte, `line_o` stays 1 after the guard period.
- R11: Changes to `tx_data`, `inv_conv`, `odd_par` and `ratio_sel` after the accepting edge do not alter the frame in progress or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock; one cycle is one basic-clock period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ratio_sel | input | 2 | Selects the etu length in clock cycles |
| inv_conv | input | 1 | 1 selects the inverse convention |
| odd_par | input | 1 | 1 selects odd parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| line_o | output | 1 | Line drive: 1 released/idle, 0 pulled low |
| tx_end | output | 1 | Transmit-end flag |

## Verification
All results are timed from the accepting edge. Start, data and parity levels are due in the etu given by their position. The etu boundary is due exactly at cycle N, the flag at cycle 11·N+N/2 and `tx_ready` at cycle N·(10+GUARD_ETU). The bench counts edges from the accepting edge and samples on the falling edge after each counted rising edge. For every boundary it checks the last cycle before the change and the first cycle after it. Data bits are sampled in the middle of their etu.

// File: rtl/sc_blk_pkg.sv
package sc_blk_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned MAX_RATIO  = 372;
  localparam int unsigned CNT_W      = $clog2(MAX_RATIO + 1);

  typedef enum logic [1:0] {
    RATIO_32  = 2'b00,
    RATIO_64  = 2'b01,
    RATIO_372 = 2'b10,
    RATIO_256 = 2'b11
  } ratio_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_e;

  function automatic logic [CNT_W-1:0] ratio_cycles(input logic [1:0] sel);
    logic [CNT_W-1:0] r;
    case (ratio_e'(sel))
      RATIO_32:  r = CNT_W'(32);
      RATIO_64:  r = CNT_W'(64);
      RATIO_372: r = CNT_W'(372);
      default:   r = CNT_W'(256);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer
  import sc_blk_pkg::*;
#(
  parameter int unsigned ETU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [1:0]       ratio_sel,
  output logic             etu_last,
  output logic             half_hit,
  output logic [ETU_W-1:0] etu_idx
);

  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic [ETU_W-1:0] etu_q, etu_d;
  logic             tmr_en;

  assign etu_last = (cyc_q == lim_q - CNT_W'(1));
  assign half_hit = (cyc_q == (lim_q >> 1) - CNT_W'(1));
  assign etu_idx  = etu_q;
  assign tmr_en   = load | run;

  always_comb begin
    lim_d = lim_q;
    cyc_d = cyc_q;
    etu_d = etu_q;
    if (load) begin
      lim_d = ratio_cycles(ratio_sel);
      cyc_d = '0;
      etu_d = '0;
    end else if (run) begin
      if (etu_last) begin
        cyc_d = '0;
        etu_d = etu_q + ETU_W'(1);
      end else begin
        cyc_d = cyc_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= CNT_W'(32);
      cyc_q <= '0;
      etu_q <= '0;
    end else if (tmr_en) begin
      lim_q <= lim_d;
      cyc_q <= cyc_d;
      etu_q <= etu_d;
    end
  end

  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc_q < lim_q)); // R3

  AST_LIM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == CNT_W'(32)) || (lim_q == CNT_W'(64)) ||
    (lim_q == CNT_W'(256)) || (lim_q == CNT_W'(372))); // R3

  AST_LIM_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(lim_q)); // R11

endmodule

// File: rtl/sc_char_fmt.sv
module sc_char_fmt
  import sc_blk_pkg::*;
(
  input  logic [DATA_W-1:0]     data,
  input  logic                  inv_conv,
  input  logic                  odd_par,
  output logic [FRAME_BITS-1:0] frame
);

  logic [DATA_W-1:0] ordered;
  logic              par_bit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign ordered[i] = inv_conv ? ~data[DATA_W-1-i] : data[i];
  end

  assign par_bit = (^data) ^ odd_par;
  assign frame   = {par_bit, ordered, 1'b0};

endmodule

// File: rtl/sc_tx_seq.sv
module sc_tx_seq
  import sc_blk_pkg::*;
#(
  parameter int unsigned GUARD_ETU = 2,
  parameter int unsigned ETU_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_valid,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  etu_last,
  input  logic                  half_hit,
  input  logic [ETU_W-1:0]      etu_idx,
  output logic                  load,
  output logic                  run,
  output logic                  tx_ready,
  output logic                  line_o,
  output logic                  tx_end
);

  localparam int unsigned LAST_ETU = FRAME_BITS + GUARD_ETU - 1;
  localparam int unsigned END_ETU  = FRAME_BITS + 1;

  seq_e                  state_q, state_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic                  line_q, line_d;
  logic                  end_q, end_d;
  logic                  accept;
  logic                  seq_en;

  assign accept   = tx_valid && (state_q == ST_IDLE);
  assign load     = accept;
  assign run      = (state_q == ST_BUSY);
  assign seq_en   = accept | run;
  assign tx_ready = (state_q == ST_IDLE);
  assign line_o   = line_q;
  assign tx_end   = end_q;

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    line_d  = line_q;
    end_d   = end_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_BUSY;
          shift_d = {1'b1, frame_in[FRAME_BITS-1:1]};
          line_d  = frame_in[0];
          end_d   = 1'b0;
        end
      end
      default: begin
        if (etu_last) begin
          line_d  = shift_q[0];
          shift_d = {1'b1, shift_q[FRAME_BITS-1:1]};
          if (etu_idx == ETU_W'(LAST_ETU)) begin
            state_d = ST_IDLE;
            line_d  = 1'b1;
          end
        end
        if (half_hit && (etu_idx == ETU_W'(END_ETU))) begin
          end_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '1;
      line_q  <= 1'b1;
      end_q   <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      shift_q <= shift_d;
      line_q  <= line_d;
      end_q   <= end_d;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> line_q); // R10

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !line_q); // R4

  AST_LINE_HOLD_IN_ETU: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !etu_last) |=> $stable(line_q)); // R4

  AST_GUARD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (etu_idx >= ETU_W'(FRAME_BITS))) |-> line_q); // R8

  AST_END_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !end_q); // R9

  AST_END_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_q) |-> (run && (etu_idx == ETU_W'(END_ETU)))); // R9

endmodule

// File: rtl/sc_blk_tx.sv
module sc_blk_tx
  import sc_blk_pkg::*;
#(
  parameter int unsigned GUARD_ETU = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ratio_sel,
  input  logic        inv_conv,
  input  logic        odd_par,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        line_o,
  output logic        tx_end
);

  localparam int unsigned GUARD_EFF = (GUARD_ETU < 2) ? 2 : GUARD_ETU;
  localparam int unsigned ETU_W     = $clog2(FRAME_BITS + GUARD_EFF + 1);

  logic [FRAME_BITS-1:0] frame;
  logic                  load;
  logic                  run;
  logic                  etu_last;
  logic                  half_hit;
  logic [ETU_W-1:0]      etu_idx;

  sc_char_fmt u_fmt (
    .data     (tx_data),
    .inv_conv (inv_conv),
    .odd_par  (odd_par),
    .frame    (frame)
  );

  sc_etu_timer #(
    .ETU_W (ETU_W)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .run       (run),
    .ratio_sel (ratio_sel),
    .etu_last  (etu_last),
    .half_hit  (half_hit),
    .etu_idx   (etu_idx)
  );

  sc_tx_seq #(
    .GUARD_ETU (GUARD_EFF),
    .ETU_W     (ETU_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .frame_in (frame),
    .etu_last (etu_last),
    .half_hit (half_hit),
    .etu_idx  (etu_idx),
    .load     (load),
    .run      (run),
    .tx_ready (tx_ready),
    .line_o   (line_o),
    .tx_end   (tx_end)
  );

  AST_READY_MATCHES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R2

endmodule

// File: tb/sim_sc_blk_tx.sv
`timescale 1ns/1ps
module sim_sc_blk_tx;

  localparam int GUARD = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ratio_sel;
  logic       inv_conv;
  logic       odd_par;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       line_o;
  logic       tx_end;

  int total = 0;
  int fails = 0;
  int pos   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  sc_blk_tx #(.GUARD_ETU(GUARD)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .inv_conv  (inv_conv),
    .odd_par   (odd_par),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .line_o    (line_o),
    .tx_end    (tx_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_to(input int m);
    repeat (m - pos) @(posedge clk);
    @(negedge clk);
    pos = m;
  endtask

  function automatic int ratio_of(input int sel);
    case (sel)
      0: return 32;
      1: return 64;
      2: return 372;
      default: return 256;
    endcase
  endfunction

  function automatic logic exp_bit(input int k, input logic [7:0] d, input bit inv, input bit odd);
    if (k == 0) return 1'b0;
    if (k <= 8) return inv ? ~d[8-k] : d[k-1];
    if (k == 9) return (^d) ^ odd;
    return 1'b1;
  endfunction

  task automatic send_frame(input int sel, input bit inv, input bit odd, input logic [7:0] d);
    int n;
    n = ratio_of(sel);
    check(tx_ready === 1'b1, "R2 ready before load", int'(tx_ready), 1);
    ratio_sel = 2'(sel);
    inv_conv  = inv;
    odd_par   = odd;
    tx_data   = d;
    tx_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pos = 0;
    tx_valid  = 1'b0;
    // R11: disturb every setting once the byte is taken
    ratio_sel = 2'(sel) ^ 2'b01;
    inv_conv  = ~inv;
    odd_par   = ~odd;
    tx_data   = ~d;
    check(tx_ready === 1'b0, "R2 ready low after load", int'(tx_ready), 0);
    check(line_o === 1'b0, "R4 start bit driven", int'(line_o), 0);
    check(tx_end === 1'b0, "R9 flag cleared on accept", int'(tx_end), 0);
    for (int k = 0; k < 10; k++) begin
      wait_to(k * n + n / 2);
      check(line_o === exp_bit(k, d, inv, odd),
            (k == 9) ? "R7 parity" : (k == 0) ? "R4 start" : inv ? "R6 inverse bit" : "R5 direct bit",
            int'(line_o), int'(exp_bit(k, d, inv, odd)));
      if (k == 0) begin
        wait_to(n - 1);
        check(line_o === 1'b0, "R3 start lasts N", int'(line_o), 0);
        wait_to(n);
        check(line_o === exp_bit(1, d, inv, odd), "R3 boundary at N", int'(line_o),
              int'(exp_bit(1, d, inv, odd)));
      end
      if (k == 2) begin
        tx_valid = 1'b1;
        tx_data  = 8'hA5;
      end
      if (k == 3) begin
        check(tx_ready === 1'b0, "R2 ready low while busy", int'(tx_ready), 0);
        tx_valid = 1'b0;
      end
    end
    wait_to(10 * n + n / 2);
    check(line_o === 1'b1, "R8 guard released", int'(line_o), 1);
    wait_to(11 * n + n / 2 - 1);
    check(tx_end === 1'b0, "R9 flag not early", int'(tx_end), 0);
    wait_to(11 * n + n / 2);
    check(tx_end === 1'b1, "R9 flag at 11.5 etu", int'(tx_end), 1);
    wait_to((10 + GUARD) * n - 1);
    check(tx_ready === 1'b0, "R8 ready held through guard", int'(tx_ready), 0);
    check(line_o === 1'b1, "R8 line high at guard end", int'(line_o), 1);
    wait_to((10 + GUARD) * n);
    check(tx_ready === 1'b1, "R8 ready after guard", int'(tx_ready), 1);
    wait_to((10 + GUARD) * n + 2);
    check(line_o === 1'b1, "R10 no repeat", int'(line_o), 1);
    check(tx_end === 1'b1, "R9 flag held idle", int'(tx_end), 1);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles >= 200000 && !done) begin
        done = 1'b1;
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] d;
    rst_n     = 1'b0;
    ratio_sel = 2'b00;
    inv_conv  = 1'b0;
    odd_par   = 1'b0;
    tx_data   = 8'h00;
    tx_valid  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_ready === 1'b1, "R1 ready at reset", int'(tx_ready), 1);
    check(line_o === 1'b1, "R1 line at reset", int'(line_o), 1);
    check(tx_end === 1'b0, "R1 flag at reset", int'(tx_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int sel = 0; sel < 4; sel++) begin
      for (int combo = 0; combo < 4; combo++) begin
        for (int b = 0; b < 3; b++) begin
          d = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : 8'(sel * 53 + combo * 29 + 17);
          send_frame(sel, combo[0], combo[1], d);
        end
      end
    end
    repeat (1000) @(negedge clk);
    check(line_o === 1'b1, "R10 line idle after long wait", int'(line_o), 1);
    check(tx_ready === 1'b1, "R10 ready idle", int'(tx_ready), 1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule